// File: doc/BRIEF.md
# Memory Access Violation Monitor

This block sits beside the CPU and the DMA engine of a small microcontroller and watches their bus control signals every cycle. It compares the program counter and the two access addresses against fixed address windows: the trusted attestation code, the reserved stack, the secret key store and the application RAM. Whenever an access or an interrupt breaks the access policy, it sets a flag in a 16-bit status word. The monitor never resets the system. Recovery or prevention logic reads the status word and an aggregate alarm, then picks its own response.

Each of the ten violation types has its own flag bit. A flag stays set until a hardware reset, or until the trusted recovery logic pulses a clear input. Software can only read the status word; it has no path for writing it. CPU accesses and DMA accesses are classified independently, so both can raise flags in the same cycle. All window bounds are module parameters, and every address comparison includes both bounds.

Top module: `mem_guard_monitor`

## Requirements
- R1: While reset is held, and after it is released with no violation, `status_o` is 16'h0000 and `alarm_o` is 0.
- R2: An interrupt (`irq_i`=1) while the PC lies in application RAM sets bit 0. An interrupt while the PC lies in the attestation code sets bit 1. An interrupt with the PC in neither window sets nothing.
- R3: While the PC lies in the attestation code, a CPU write (`cpu_wr_i`) to application RAM sets bit 6, and a DMA write (`dma_en_i`=1, `dma_wr_i`=1) to application RAM sets bit 2. The same writes with the PC outside the attestation code set nothing.
- R4: While the PC lies in the attestation code, a CPU read of application RAM sets bit 7, and a DMA read (`dma_en_i`=1, `dma_wr_i`=0) of application RAM sets bit 3.
- R5: A CPU read of the reserved stack with the PC outside the attestation code sets bit 8. The same read by DMA sets bit 4. Stack reads with the PC inside the attestation code set nothing.
- R6: A CPU read of the key store with the PC outside the attestation code sets bit 9. The same read by DMA sets bit 5. Key reads with the PC inside the attestation code set nothing.
- R7: Every window comparison is inclusive at both the lower and the upper bound. An address one below the lower bound, or one above the upper bound, is outside the window.
- R8: A violation present in cycle n is visible on `status_o` right after the rising edge that ends cycle n.
- R9: Flags are sticky until `clr_i`=1. A clear zeroes all flags, except that a violation in the same cycle as the clear still sets its flag.
- R10: `alarm_o` is 1 exactly when at least one bit of `status_o` is 1.
- R11: A CPU violation and a DMA violation in the same cycle both set their flags.
- R12: Bits 15 down to 10 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| clr_i | input | 1 | Clear of all flags, driven by the trusted recovery logic |
| pc_i | input | AW | Program counter |
| irq_i | input | 1 | Interrupt request |
| cpu_rd_i | input | 1 | CPU read enable |
| cpu_wr_i | input | 1 | CPU write enable |
| cpu_addr_i | input | AW | CPU data address |
| dma_en_i | input | 1 | DMA access enable |
| dma_wr_i | input | 1 | DMA direction: 1 means write, 0 means read |
| dma_addr_i | input | AW | DMA address |
| status_o | output | 16 | Read-only violation flags (bits 9 to 0), with zeros above them |
| alarm_o | output | 1 | OR of all flags |

## Verification
The classification is combinational and feeds a single register, so the flags from one stimulus cycle are due right after the next rising edge. The alarm follows those flags with no further delay. The driver applies one stimulus per cycle at the falling edge and pushes the expected status into a queue. The monitor pops that entry a quarter period after the following rising edge and compares the full status word and the alarm. The expected word is accumulated in the bench from the bit meanings given in the requirements, so stickiness and clearing are checked cycle by cycle.

// File: rtl/mgm_pkg.sv
package mgm_pkg;
  localparam int unsigned STATUS_W = 16;
  localparam int unsigned NFLAG    = 10;

  // flag bit positions (decoded by downstream recovery logic)
  localparam int unsigned F_IRQ_APP  = 0;
  localparam int unsigned F_IRQ_ATT  = 1;
  localparam int unsigned F_DMA_WRAM = 2;
  localparam int unsigned F_DMA_RRAM = 3;
  localparam int unsigned F_DMA_RSTK = 4;
  localparam int unsigned F_DMA_RKEY = 5;
  localparam int unsigned F_CPU_WRAM = 6;
  localparam int unsigned F_CPU_RRAM = 7;
  localparam int unsigned F_CPU_RSTK = 8;
  localparam int unsigned F_CPU_RKEY = 9;

  // window index used for the per-requester address decode
  localparam int unsigned W_APP = 0;
  localparam int unsigned W_STK = 1;
  localparam int unsigned W_KEY = 2;
  localparam int unsigned NWIN  = 3;

  // requester index
  localparam int unsigned RQ_CPU = 0;
  localparam int unsigned RQ_DMA = 1;
  localparam int unsigned NRQ    = 2;
endpackage

// File: rtl/mgm_rst_sync.sv
module mgm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mgm_range.sv
module mgm_range #(
  parameter int unsigned     AW = 16,
  parameter logic [AW-1:0]   LO = '0,
  parameter logic [AW-1:0]   HI = '1
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  // both bounds inclusive
  assign hit_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/mgm_classify.sv
module mgm_classify
  import mgm_pkg::*;
(
  input  logic                       pc_att_i,
  input  logic                       pc_app_i,
  input  logic                       irq_i,
  input  logic                       cpu_rd_i,
  input  logic                       cpu_wr_i,
  input  logic [NWIN-1:0]            cpu_hit_i,
  input  logic                       dma_en_i,
  input  logic                       dma_wr_i,
  input  logic [NWIN-1:0]            dma_hit_i,
  output logic [NFLAG-1:0]           viol_o
);
  logic dma_rd, dma_wr;

  always_comb begin
    dma_rd = dma_en_i & ~dma_wr_i;
    dma_wr = dma_en_i &  dma_wr_i;
    viol_o = '0;
    // atomicity
    viol_o[F_IRQ_APP]  = irq_i & pc_app_i;
    viol_o[F_IRQ_ATT]  = irq_i & pc_att_i;
    // DMA side
    viol_o[F_DMA_WRAM] = dma_wr & dma_hit_i[W_APP] &  pc_att_i;
    viol_o[F_DMA_RRAM] = dma_rd & dma_hit_i[W_APP] &  pc_att_i;
    viol_o[F_DMA_RSTK] = dma_rd & dma_hit_i[W_STK] & ~pc_att_i;
    viol_o[F_DMA_RKEY] = dma_rd & dma_hit_i[W_KEY] & ~pc_att_i;
    // CPU side
    viol_o[F_CPU_WRAM] = cpu_wr_i & cpu_hit_i[W_APP] &  pc_att_i;
    viol_o[F_CPU_RRAM] = cpu_rd_i & cpu_hit_i[W_APP] &  pc_att_i;
    viol_o[F_CPU_RSTK] = cpu_rd_i & cpu_hit_i[W_STK] & ~pc_att_i;
    viol_o[F_CPU_RKEY] = cpu_rd_i & cpu_hit_i[W_KEY] & ~pc_att_i;
  end
endmodule

// File: rtl/mem_guard_monitor.sv
module mem_guard_monitor
  import mgm_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] ATT_LO = 16'hA000,
  parameter logic [AW-1:0] ATT_HI = 16'hA7FF,
  parameter logic [AW-1:0] APP_LO = 16'h0200,
  parameter logic [AW-1:0] APP_HI = 16'h1FFF,
  parameter logic [AW-1:0] STK_LO = 16'h6000,
  parameter logic [AW-1:0] STK_HI = 16'h67FF,
  parameter logic [AW-1:0] KEY_LO = 16'hFE00,
  parameter logic [AW-1:0] KEY_HI = 16'hFE1F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [AW-1:0]       pc_i,
  input  logic                irq_i,
  input  logic                cpu_rd_i,
  input  logic                cpu_wr_i,
  input  logic [AW-1:0]       cpu_addr_i,
  input  logic                dma_en_i,
  input  logic                dma_wr_i,
  input  logic [AW-1:0]       dma_addr_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                alarm_o
);
  logic                  rst_sync_n;
  logic                  pc_att, pc_app;
  logic [AW-1:0]         rq_addr [NRQ];
  logic [NWIN-1:0]       rq_hit  [NRQ];
  logic [NFLAG-1:0]      viol;
  logic [NFLAG-1:0]      flag_q, flag_d;
  logic                  flag_en;

  mgm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // program counter windows
  mgm_range #(.AW(AW), .LO(ATT_LO), .HI(ATT_HI)) u_pc_att (.addr_i(pc_i), .hit_o(pc_att));
  mgm_range #(.AW(AW), .LO(APP_LO), .HI(APP_HI)) u_pc_app (.addr_i(pc_i), .hit_o(pc_app));

  assign rq_addr[RQ_CPU] = cpu_addr_i;
  assign rq_addr[RQ_DMA] = dma_addr_i;

  // data-address windows, one decoder per requester and window
  for (genvar r = 0; r < NRQ; r++) begin : g_rq
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [AW-1:0] LO_W = (w == W_APP) ? APP_LO : (w == W_STK) ? STK_LO : KEY_LO;
      localparam logic [AW-1:0] HI_W = (w == W_APP) ? APP_HI : (w == W_STK) ? STK_HI : KEY_HI;
      mgm_range #(.AW(AW), .LO(LO_W), .HI(HI_W)) u_win (
        .addr_i(rq_addr[r]), .hit_o(rq_hit[r][w])
      );
    end
  end

  mgm_classify u_classify (
    .pc_att_i (pc_att),
    .pc_app_i (pc_app),
    .irq_i    (irq_i),
    .cpu_rd_i (cpu_rd_i),
    .cpu_wr_i (cpu_wr_i),
    .cpu_hit_i(rq_hit[RQ_CPU]),
    .dma_en_i (dma_en_i),
    .dma_wr_i (dma_wr_i),
    .dma_hit_i(rq_hit[RQ_DMA]),
    .viol_o   (viol)
  );

  // sticky flags: new violations win over a simultaneous clear
  always_comb begin
    flag_en = clr_i | (|viol);
    flag_d  = (clr_i ? '0 : flag_q) | viol;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign status_o = {{(STATUS_W-NFLAG){1'b0}}, flag_q};
  assign alarm_o  = |flag_q;

  // R12: reserved bits stay zero
  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_o[STATUS_W-1:NFLAG] == '0);

  // R9: without a clear, no flag ever drops
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_i |=> ((status_o[NFLAG-1:0] & $past(status_o[NFLAG-1:0])) == $past(status_o[NFLAG-1:0])));

  // R9: clear with no new violation empties the word
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_i && viol == '0) |=> (status_o == '0));

  // R10: alarm only rises because of a classified violation
  p_alarm_cause_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(alarm_o) |-> $past(viol != '0));

  // R8: every classified violation is on the port after the next edge
  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    p_detect_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      viol[i] |=> status_o[i]);
  end
endmodule

// File: tb/mem_guard_monitor_bench.sv
module mem_guard_monitor_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] PC_APP = 16'h0400;
  localparam logic [15:0] PC_ATT = 16'hA100;
  localparam logic [15:0] PC_OTH = 16'h3000;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i;
  logic [15:0] pc_i;
  logic        irq_i, cpu_rd_i, cpu_wr_i, dma_en_i, dma_wr_i;
  logic [15:0] cpu_addr_i, dma_addr_i;
  logic [15:0] status_o;
  logic        alarm_o;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [15:0] model  = '0;
  item_t       sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_guard_monitor u_mem_guard_monitor (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .pc_i(pc_i), .irq_i(irq_i),
    .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i),
    .dma_en_i(dma_en_i), .dma_wr_i(dma_wr_i), .dma_addr_i(dma_addr_i),
    .status_o(status_o), .alarm_o(alarm_o)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one stimulus cycle, expected flags pushed to the scoreboard
  task automatic step(input logic [15:0] pc, input logic irq,
                      input logic crd, input logic cwr, input logic [15:0] caddr,
                      input logic den, input logic dwr, input logic [15:0] daddr,
                      input logic clr, input logic [15:0] set_mask, input string tag);
    item_t it;
    @(negedge clk);
    pc_i = pc; irq_i = irq; cpu_rd_i = crd; cpu_wr_i = cwr; cpu_addr_i = caddr;
    dma_en_i = den; dma_wr_i = dwr; dma_addr_i = daddr; clr_i = clr;
    model = (clr ? 16'h0 : model) | set_mask;
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(PC_OTH, 0, 0, 0, 16'h0, 0, 0, 16'h0, 0, 16'h0, tag);
  endtask

  task automatic clear(input string tag);
    step(PC_OTH, 0, 0, 0, 16'h0, 0, 0, 16'h0, 1, 16'h0, tag);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(status_o, it.exp, {it.tag, " status (R8/R12)"});
        check({15'h0, alarm_o}, {15'h0, it.exp != 16'h0}, {it.tag, " alarm R10"});
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_i = 0; pc_i = PC_OTH; irq_i = 0; cpu_rd_i = 0; cpu_wr_i = 0;
    cpu_addr_i = 0; dma_en_i = 0; dma_wr_i = 0; dma_addr_i = 0;
    // R1: attempted violation during reset has no effect
    irq_i = 1; pc_i = PC_APP;
    repeat (3) @(negedge clk);
    check(status_o, 16'h0, "R1 reset status");
    check({15'h0, alarm_o}, 16'h0, "R1 reset alarm");
    irq_i = 0; pc_i = PC_OTH;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle("R1 idle after reset");
    // R2 atomicity
    step(PC_APP, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0001, "R2 irq in app");
    idle("R9 sticky hold");
    idle("R9 sticky hold 2");
    clear("R9 clear");
    step(PC_ATT, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0002, "R2 irq in att");
    clear("R9 clear");
    step(PC_OTH, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, "R2 irq elsewhere");
    // R3 writes into app RAM during attestation, both bounds (R7)
    step(PC_ATT, 0, 0, 1, 16'h0200, 0, 0, 0, 0, 16'h0040, "R3 R7 cpu write app lo");
    step(PC_ATT, 0, 0, 0, 0, 1, 1, 16'h1FFF, 0, 16'h0004, "R3 R7 dma write app hi");
    clear("R9 clear");
    step(PC_APP, 0, 0, 1, 16'h0800, 1, 1, 16'h0800, 0, 16'h0000, "R3 writes outside att");
    step(PC_ATT, 0, 0, 1, 16'h01FF, 1, 1, 16'h2000, 0, 16'h0000, "R7 writes just outside app");
    // R4 reads of app RAM during attestation, same cycle (R11)
    step(PC_ATT, 0, 1, 0, 16'h1000, 1, 0, 16'h0300, 0, 16'h0088, "R4 R11 cpu+dma read app");
    clear("R9 clear");
    // R5 stack reads outside attestation
    step(PC_APP, 0, 1, 0, 16'h6000, 0, 0, 0, 0, 16'h0100, "R5 cpu read stk lo");
    step(PC_OTH, 0, 0, 0, 0, 1, 0, 16'h67FF, 0, 16'h0010, "R5 dma read stk hi");
    clear("R9 clear");
    step(PC_ATT, 0, 1, 0, 16'h6400, 1, 0, 16'h6400, 0, 16'h0000, "R5 stack reads in att");
    step(PC_APP, 0, 1, 0, 16'h6800, 1, 0, 16'h5FFF, 0, 16'h0000, "R7 just outside stk");
    // R6 key reads
    step(PC_APP, 0, 1, 0, 16'hFE1F, 1, 0, 16'hFE00, 0, 16'h0220, "R6 R11 key reads outside att");
    clear("R9 clear");
    step(PC_ATT, 0, 1, 0, 16'hFE10, 1, 0, 16'hFE10, 0, 16'h0000, "R6 key reads in att");
    step(16'hA7FF, 0, 1, 0, 16'hFE00, 0, 0, 0, 0, 16'h0000, "R7 pc att hi key read");
    step(16'hA800, 0, 1, 0, 16'hFE00, 0, 0, 0, 0, 16'h0200, "R7 pc past att key read");
    step(PC_APP, 0, 1, 0, 16'hFDFF, 0, 0, 0, 0, 16'h0000, "R7 below key lo");
    // R9 set wins over clear in the same cycle
    step(PC_APP, 1, 0, 0, 0, 0, 0, 0, 1, 16'h0001, "R9 clear with new irq");
    idle("R9 sticky after clear");
    clear("R9 final clear");
    idle("R1 quiet end");

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule